// File: doc/BRIEF.md
# Six-Step Brushless Motor Commutation Decoder

This block turns the three rotor-position sensor bits of a three-phase brushless motor into six gate-drive enables: one high-side and one low-side enable for each phase. On each clock edge it registers a new drive pattern. The pattern follows from the decoded commutation step, the rotation direction, and the state of the brake, enable and overcurrent inputs. It also drives an active-low fault line. Pulse-width gating of the low-side drives, the modulator timing and the analog comparators all sit outside this block.

Two sensor layouts are supported, and a select pin chooses between them. With 120° spacing the codes 000 and 111 never appear in a healthy motor, so they are treated as invalid. With 60° spacing the codes 010 and 101 are the invalid ones. Every invalid code raises the fault line. A fixed priority settles the overlap between a bad sensor code, brake, enable and overcurrent, so the outputs are defined for every input combination. Braking always releases all high-side switches and closes all low-side switches. An overcurrent forces every low-side switch open, even during a brake.

Top module: `bldc_step_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the outputs after that edge are: all high-side enables off (`top_drv_n` = 3'b111), all low-side enables off (`bot_drv` = 3'b000), and `fault_n` = 0.
- R2: With `sel_60deg`=0, the sensor code {hall_a,hall_b,hall_c} maps to steps 0..5 in the order 101, 100, 110, 010, 011, 001. Codes 000 and 111 are invalid.
- R3: With `sel_60deg`=1, the sensor code maps to steps 0..5 in the order 000, 100, 110, 111, 011, 001. Codes 010 and 101 are invalid.
- R4: In run (valid code, brake=0, enable=1, over_cur=0), exactly one high-side and one low-side enable are on, and `fault_n`=1. With `dir_rev`=0, step k turns on the high side of phase floor(k/2) and the low side of phase (floor(k/2)+1+(k mod 2)) mod 3. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R5: With `dir_rev`=1 in run, the phases chosen for the high side and the low side are exchanged relative to R4.
- R6: An invalid code with brake=0 turns every drive off and sets `fault_n`=0.
- R7: An invalid code with brake=1 and over_cur=0 turns all high sides off, turns all low sides on, and sets `fault_n`=0.
- R8: A valid code with brake=1, enable=1 and over_cur=0 turns all high sides off and all low sides on, with `fault_n`=1.
- R9: A valid code with brake=1, enable=0 and over_cur=0 turns all high sides off and all low sides on, with `fault_n`=0.
- R10: A valid code with brake=0 and enable=0 turns every drive off and sets `fault_n`=0.
- R11: With over_cur=1, all low-side enables are off and `fault_n`=0. The high-side enables are whatever the other inputs would select.
- R12: Outputs change only at a clock edge, one cycle after the inputs that cause them.
- R13: No phase ever has its high-side and low-side enables on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_a | input | 1 | Position sensor bit, phase A (code MSB) |
| hall_b | input | 1 | Position sensor bit, phase B |
| hall_c | input | 1 | Position sensor bit, phase C (code LSB) |
| sel_60deg | input | 1 | 1: 60° sensor spacing, 0: 120° spacing |
| dir_rev | input | 1 | 1: reverse rotation |
| brake | input | 1 | 1: brake request |
| enable | input | 1 | 1: drive enabled |
| over_cur | input | 1 | 1: overcurrent from the current-limit stage |
| top_drv_n | output | 3 | High-side enables, active low, bit 0 = phase A |
| bot_drv | output | 3 | Low-side enables, active high, bit 0 = phase A |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The bench builds the block with its only configuration: three phases and a three-bit sensor code. That configuration has just eight single-bit inputs, so the bench sweeps all 256 input combinations. It compares every result with a model that derives the sensor cycles and step-to-phase mapping arithmetically, not from a lookup table. Because the sweep is complete, every priority overlap is exercised: an invalid code during a brake, overcurrent during a brake, and direction in every step of both sensor modes. Each new combination is also checked against the previous output before the clock edge, which confirms the one-cycle registration.

// File: rtl/bldc_step_pkg.sv
package bldc_step_pkg;

  localparam int unsigned PHASES = 3;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned STEPS  = 2 * PHASES;
  localparam int unsigned STEP_W = $clog2(STEPS);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PHASES-1:0] phase_vec_t;

  typedef struct packed {
    logic  valid;
    step_t step;
  } hall_dec_t;

  typedef struct packed {
    phase_vec_t top_on;
    phase_vec_t bot_on;
    logic       fault;
  } drive_t;

  // 120 degree spacing: 000 and 111 never occur
  function automatic hall_dec_t dec_120(input code_t c);
    hall_dec_t r;
    r.valid = 1'b1;
    unique case (c)
      3'b101:  r.step = step_t'(0);
      3'b100:  r.step = step_t'(1);
      3'b110:  r.step = step_t'(2);
      3'b010:  r.step = step_t'(3);
      3'b011:  r.step = step_t'(4);
      3'b001:  r.step = step_t'(5);
      default: begin r.valid = 1'b0; r.step = '0; end
    endcase
    return r;
  endfunction

  // 60 degree spacing: 010 and 101 never occur
  function automatic hall_dec_t dec_60(input code_t c);
    hall_dec_t r;
    r.valid = 1'b1;
    unique case (c)
      3'b000:  r.step = step_t'(0);
      3'b100:  r.step = step_t'(1);
      3'b110:  r.step = step_t'(2);
      3'b111:  r.step = step_t'(3);
      3'b011:  r.step = step_t'(4);
      3'b001:  r.step = step_t'(5);
      default: begin r.valid = 1'b0; r.step = '0; end
    endcase
    return r;
  endfunction

  // forward-rotation high-side phase for a step (one-hot)
  function automatic phase_vec_t fwd_top(input step_t s);
    case (s)
      step_t'(0), step_t'(1): return phase_vec_t'(3'b001);
      step_t'(2), step_t'(3): return phase_vec_t'(3'b010);
      step_t'(4), step_t'(5): return phase_vec_t'(3'b100);
      default:                return '0;
    endcase
  endfunction

  // forward-rotation low-side phase for a step (one-hot)
  function automatic phase_vec_t fwd_bot(input step_t s);
    case (s)
      step_t'(0), step_t'(5): return phase_vec_t'(3'b010);
      step_t'(1), step_t'(2): return phase_vec_t'(3'b100);
      step_t'(3), step_t'(4): return phase_vec_t'(3'b001);
      default:                return '0;
    endcase
  endfunction

endpackage

// File: rtl/bldc_hall_decode.sv
module bldc_hall_decode
  import bldc_step_pkg::*;
(
  input  code_t code,
  input  logic  sel_60deg,
  output logic  valid,
  output step_t step
);

  hall_dec_t d120, d60, dsel;

  always_comb begin
    d120 = dec_120(code);
    d60  = dec_60(code);
    dsel = sel_60deg ? d60 : d120;
  end

  assign valid = dsel.valid;
  assign step  = dsel.step;

endmodule

// File: rtl/bldc_phase_map.sv
module bldc_phase_map
  import bldc_step_pkg::*;
(
  input  step_t      step,
  input  logic       dir_rev,
  output phase_vec_t top_on,
  output phase_vec_t bot_on
);

  phase_vec_t f_top, f_bot;

  always_comb begin
    f_top = fwd_top(step);
    f_bot = fwd_bot(step);
  end

  // reverse rotation drives current the other way: swap the two sides
  assign top_on = dir_rev ? f_bot : f_top;
  assign bot_on = dir_rev ? f_top : f_bot;

endmodule

// File: rtl/bldc_drive_arbiter.sv
module bldc_drive_arbiter
  import bldc_step_pkg::*;
(
  input  logic       valid,
  input  logic       brake,
  input  logic       enable,
  input  logic       over_cur,
  input  phase_vec_t run_top,
  input  phase_vec_t run_bot,
  output drive_t     nxt
);

  drive_t base;

  // priority: sensor validity, then brake, then enable, then run
  always_comb begin
    base = '0;
    if (!valid) begin
      base.top_on = '0;
      base.bot_on = brake ? '1 : '0;
      base.fault  = 1'b1;
    end else if (brake) begin
      base.top_on = '0;
      base.bot_on = '1;
      base.fault  = !enable;
    end else if (!enable) begin
      base.top_on = '0;
      base.bot_on = '0;
      base.fault  = 1'b1;
    end else begin
      base.top_on = run_top;
      base.bot_on = run_bot;
      base.fault  = 1'b0;
    end
  end

  // overcurrent overrides the low side in every state
  always_comb begin
    nxt = base;
    if (over_cur) begin
      nxt.bot_on = '0;
      nxt.fault  = 1'b1;
    end
  end

endmodule

// File: rtl/bldc_step_decoder.sv
module bldc_step_decoder
  import bldc_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hall_a,
  input  logic              hall_b,
  input  logic              hall_c,
  input  logic              sel_60deg,
  input  logic              dir_rev,
  input  logic              brake,
  input  logic              enable,
  input  logic              over_cur,
  output logic [PHASES-1:0] top_drv_n,
  output logic [PHASES-1:0] bot_drv,
  output logic              fault_n
);

  code_t      hall_code;
  logic       code_valid;
  step_t      step_idx;
  phase_vec_t run_top, run_bot;
  drive_t     drv_next;

  assign hall_code = {hall_a, hall_b, hall_c};

  bldc_hall_decode u_dec (
    .code      (hall_code),
    .sel_60deg (sel_60deg),
    .valid     (code_valid),
    .step      (step_idx)
  );

  bldc_phase_map u_map (
    .step    (step_idx),
    .dir_rev (dir_rev),
    .top_on  (run_top),
    .bot_on  (run_bot)
  );

  bldc_drive_arbiter u_arb (
    .valid    (code_valid),
    .brake    (brake),
    .enable   (enable),
    .over_cur (over_cur),
    .run_top  (run_top),
    .run_bot  (run_bot),
    .nxt      (drv_next)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic top_q, bot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        top_q <= 1'b1;
        bot_q <= 1'b0;
      end else begin
        top_q <= ~drv_next.top_on[p];
        bot_q <= drv_next.bot_on[p];
      end
    end
    assign top_drv_n[p] = top_q;
    assign bot_drv[p]   = bot_q;
  end

  logic fault_q;
  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= ~drv_next.fault;
  end
  assign fault_n = fault_q;

endmodule

// File: rtl/bldc_step_decoder_chk.sv
module bldc_step_decoder_chk
  import bldc_step_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              hall_a,
  input logic              hall_b,
  input logic              hall_c,
  input logic              sel_60deg,
  input logic              brake,
  input logic              enable,
  input logic              over_cur,
  input logic              code_valid,
  input logic [PHASES-1:0] top_drv_n,
  input logic [PHASES-1:0] bot_drv,
  input logic              fault_n
);

  logic [2:0] c;
  assign c = {hall_a, hall_b, hall_c};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (top_drv_n == '1 && bot_drv == '0 && !fault_n));

  p_bad_code_120_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_60deg && (c == 3'b000 || c == 3'b111)) |=> (!fault_n && top_drv_n == '1));

  p_bad_code_60_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_60deg && (c == 3'b010 || c == 3'b101)) |=> (!fault_n && top_drv_n == '1));

  p_run_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !brake && enable && !over_cur) |=>
      ($countones(~top_drv_n) == 1 && $countones(bot_drv) == 1 && fault_n));

  p_invalid_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!code_valid && !brake) |=> (top_drv_n == '1 && bot_drv == '0 && !fault_n));

  p_invalid_brake_r7: assert property (@(posedge clk) disable iff (rst)
    (!code_valid && brake && !over_cur) |=> (top_drv_n == '1 && bot_drv == '1 && !fault_n));

  p_brake_ok_r8: assert property (@(posedge clk) disable iff (rst)
    (code_valid && brake && enable && !over_cur) |=> (top_drv_n == '1 && bot_drv == '1 && fault_n));

  p_brake_dis_r9: assert property (@(posedge clk) disable iff (rst)
    (code_valid && brake && !enable && !over_cur) |=> (top_drv_n == '1 && bot_drv == '1 && !fault_n));

  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !brake && !enable) |=> (top_drv_n == '1 && bot_drv == '0 && !fault_n));

  p_overcurrent_r11: assert property (@(posedge clk) disable iff (rst)
    over_cur |=> (bot_drv == '0 && !fault_n));

  p_no_shoot_r13: assert property (@(posedge clk) disable iff (rst)
    ((~top_drv_n & bot_drv) == '0));

endmodule

bind bldc_step_decoder bldc_step_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hall_a     (hall_a),
  .hall_b     (hall_b),
  .hall_c     (hall_c),
  .sel_60deg  (sel_60deg),
  .brake      (brake),
  .enable     (enable),
  .over_cur   (over_cur),
  .code_valid (code_valid),
  .top_drv_n  (top_drv_n),
  .bot_drv    (bot_drv),
  .fault_n    (fault_n)
);

// File: tb/bldc_step_decoder_bench.sv
`timescale 1ns/1ps
module bldc_step_decoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hall_a = 0, hall_b = 0, hall_c = 0;
  logic sel_60deg = 0, dir_rev = 0, brake = 0, enable = 0, over_cur = 0;
  logic [2:0] top_drv_n, bot_drv;
  logic fault_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bldc_step_decoder u_bldc_step_decoder (
    .clk(clk), .rst(rst), .hall_a(hall_a), .hall_b(hall_b), .hall_c(hall_c),
    .sel_60deg(sel_60deg), .dir_rev(dir_rev), .brake(brake), .enable(enable),
    .over_cur(over_cur), .top_drv_n(top_drv_n), .bot_drv(bot_drv), .fault_n(fault_n)
  );

  // step k of a sensor cycle: each sensor is high for three consecutive steps,
  // starting at step 0/2/4 (120 deg) or 1/2/3 (60 deg)
  function automatic int find_step(input logic [2:0] code, input bit s60);
    for (int k = 0; k < 6; k++) begin
      logic [2:0] gen;
      for (int ph = 0; ph < 3; ph++) begin
        int start = s60 ? (ph + 1) : (2 * ph);
        gen[2 - ph] = (((k - start + 6) % 6) < 3);
      end
      if (gen == code) return k;
    end
    return -1;
  endfunction

  // returns {top_n[2:0], bot[2:0], fault_n}
  function automatic logic [6:0] model(input logic [7:0] v);
    logic [2:0] code = v[2:0];
    bit s60 = v[3], dr = v[4], br = v[5], en = v[6], oc = v[7];
    int k = find_step(code, s60);
    logic [2:0] top = 3'b000, bot = 3'b000;
    bit flt;
    if (k < 0) begin
      bot = br ? 3'b111 : 3'b000; flt = 1;
    end else if (br) begin
      bot = 3'b111; flt = !en;
    end else if (!en) begin
      flt = 1;
    end else begin
      int tp = k / 2;
      int bp = (tp + 1 + (k % 2)) % 3;
      if (dr) begin int t = tp; tp = bp; bp = t; end
      top = 3'b001 << tp; bot = 3'b001 << bp; flt = 0;
    end
    if (oc) begin bot = 3'b000; flt = 1; end
    return {~top, bot, ~flt};
  endfunction

  function automatic string tag_of(input logic [7:0] v);
    bit valid = find_step(v[2:0], v[3]) >= 0;
    if (v[7]) return "R11";
    if (!valid) return v[5] ? "R7" : "R6";
    if (v[5]) return v[6] ? "R8" : "R9";
    if (!v[6]) return "R10";
    return v[4] ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got top_n=%b bot=%b fault_n=%b, want top_n=%b bot=%b fault_n=%b",
               req, act[6:4], act[3:1], act[0], exp[6:4], exp[3:1], exp[0]);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    {over_cur, enable, brake, dir_rev, sel_60deg, hall_a, hall_b, hall_c} = v;
  endtask

  initial begin
    logic [6:0] prev;
    logic [6:0] outs;
    repeat (3) @(negedge clk);
    check("R1", {top_drv_n, bot_drv, fault_n}, 7'b111_000_0);
    rst = 1'b0;
    prev = 7'b111_000_0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v = 8'(i);
      logic [6:0] exp = model(v);
      apply(v);
      #1;
      check("R12", {top_drv_n, bot_drv, fault_n}, prev);   // no change before the edge
      @(negedge clk);
      outs = {top_drv_n, bot_drv, fault_n};
      check(tag_of(v), outs, exp);
      check("R13", {4'b0000, ~outs[6:4] & outs[3:1]}, 7'b0);
      if (!v[7] && !v[5] && v[6]) begin
        // sensor-mode classification seen at the fault line
        check(v[3] ? "R3" : "R2", {6'b0, outs[0]},
              {6'b0, 1'b1 & (find_step(v[2:0], v[3]) >= 0)});
      end
      prev = exp;
    end
    // reset in the middle of a run step
    apply({1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101});
    @(negedge clk);
    check("R4", {top_drv_n, bot_drv, fault_n}, 7'b110_010_1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {top_drv_n, bot_drv, fault_n}, 7'b111_000_0);
    rst = 1'b0;
    @(negedge clk);
    check("R4", {top_drv_n, bot_drv, fault_n}, 7'b110_010_1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule